// File: doc/BRIEF.md
# Jump Target Cache

This block sits beside the fetch stage and is looked up with the address about to be fetched. Each entry belongs to one jump instruction that leaves the sequential flow. It holds the jump's target address and the instruction word found at that target. When the fetch address matches a valid entry, the block hands the cached target instruction to decode in place of the word the jump would have fetched. It also steers the next fetch to the address after the target, so a taken jump costs no stall cycles.

Entries are written from a later pipeline stage once a jump has resolved. The same write port installs a new jump and repairs an entry whose predicted target was wrong. A separate clear port removes the entry for a given jump address. The organisation is direct-mapped. The low address bits select the slot and the remaining bits form the stored tag. All lookup outputs are combinational from the current fetch address, and writes take effect at the clock edge.

Top module: `jump_target_cache`

## Requirements
- R1: While rst_ni is low, and after it is released, every entry is invalid and no fetch address hits.
- R2: On a miss, hit_o is 0, next_pc_o equals fetch_pc_i + 1 modulo 2^ADDR_W, and insn_o and target_o read zero.
- R3: After a write for jump address P with target T and word W, a fetch at P hits with target_o = T, insn_o = W and next_pc_o = T + 1 modulo 2^ADDR_W.
- R4: The slot is chosen by fetch_pc_i[IDX_W-1:0] and the tag is the remaining upper bits. A fetch address that selects an occupied slot but carries a different tag misses.
- R5: A write to a jump address already present replaces both its target and its instruction word. This is how a mispredicted target is corrected.
- R6: A write for a new jump address that maps to an occupied slot evicts the previous jump, and the previous address then misses.
- R7: A write whose target equals its jump address + 1 is a sequential flow and is dropped, leaving the slot unchanged. No hit ever reports a target equal to the fetch address + 1.
- R8: A clear request removes the entry only when both its slot and its tag match. A clear with the same slot but another tag leaves the entry in place.
- R9: When a lookup and a write hit the same slot in the same cycle, the lookup returns the slot's contents from before the write. The new contents appear from the next cycle on.
- R10: When a clear and a write target the same jump address in the same cycle, the clear wins and the slot ends invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_pc_i | input | ADDR_W | Address being fetched |
| hit_o | output | 1 | Fetch address matches a valid entry |
| next_pc_o | output | ADDR_W | Next fetch address: target + 1 on a hit, fetch_pc_i + 1 otherwise |
| target_o | output | ADDR_W | Cached jump target on a hit, zero otherwise |
| insn_o | output | INSN_W | Cached target instruction on a hit, zero otherwise |
| upd_valid_i | input | 1 | Install or correct an entry |
| upd_pc_i | input | ADDR_W | Jump address being written |
| upd_target_i | input | ADDR_W | Resolved jump target |
| upd_insn_i | input | INSN_W | Instruction word at the resolved target |
| inv_valid_i | input | 1 | Clear request |
| inv_pc_i | input | ADDR_W | Jump address to clear |

## Verification
The bench builds the block with its defaults: a 16-bit address, 4 index bits for 16 slots, and 32-bit instruction words. With those values, addresses 0x0010, 0x0020 and 0x0030 all land in slot 0 with different tags, so aliasing, eviction and tag-checked clearing can be exercised with a handful of writes. The 16-bit address also lets a target of 0xFFFF show the wrap of the redirected fetch address to 0x0000.

// File: rtl/jtc_pkg.sv
package jtc_pkg;
  localparam int unsigned DEF_ADDR_W = 16;
  localparam int unsigned DEF_INSN_W = 32;
  localparam int unsigned DEF_IDX_W  = 4;
endpackage

// File: rtl/jtc_entry_array.sv
module jtc_entry_array #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned INSN_W = 32,
  parameter int unsigned IDX_W  = 4,
  localparam int unsigned TAG_W   = ADDR_W - IDX_W,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [ADDR_W-1:0] wr_target_i,
  input  logic [INSN_W-1:0] wr_insn_i,
  input  logic              clr_en_i,
  input  logic [IDX_W-1:0]  clr_idx_i,
  input  logic [TAG_W-1:0]  clr_tag_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [ADDR_W-1:0] rd_target_o,
  output logic [INSN_W-1:0] rd_insn_o
);
  logic              valid_a  [ENTRIES];
  logic [TAG_W-1:0]  tag_a    [ENTRIES];
  logic [ADDR_W-1:0] target_a [ENTRIES];
  logic [INSN_W-1:0] insn_a   [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic              v_q;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] tgt_q;
    logic [INSN_W-1:0] insn_q;
    logic              wr_hit, clr_hit;

    assign wr_hit  = wr_en_i && (wr_idx_i == IDX_W'(g));
    // clear matches the stored tag or the tag being written this cycle
    assign clr_hit = clr_en_i && (clr_idx_i == IDX_W'(g)) &&
                     ((v_q && tag_q == clr_tag_i) || (wr_hit && wr_tag_i == clr_tag_i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q    <= 1'b0;
        tag_q  <= '0;
        tgt_q  <= '0;
        insn_q <= '0;
      end else if (clr_hit) begin
        v_q <= 1'b0;
      end else if (wr_hit) begin
        v_q    <= 1'b1;
        tag_q  <= wr_tag_i;
        tgt_q  <= wr_target_i;
        insn_q <= wr_insn_i;
      end
    end

    assign valid_a[g]  = v_q;
    assign tag_a[g]    = tag_q;
    assign target_a[g] = tgt_q;
    assign insn_a[g]   = insn_q;
  end

  assign rd_valid_o  = valid_a[rd_idx_i];
  assign rd_tag_o    = tag_a[rd_idx_i];
  assign rd_target_o = target_a[rd_idx_i];
  assign rd_insn_o   = insn_a[rd_idx_i];
endmodule

// File: rtl/jtc_lookup.sv
module jtc_lookup #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned INSN_W = 32,
  parameter int unsigned IDX_W  = 4,
  localparam int unsigned TAG_W = ADDR_W - IDX_W
) (
  input  logic [ADDR_W-1:0] fetch_pc_i,
  input  logic              rd_valid_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic [ADDR_W-1:0] rd_target_i,
  input  logic [INSN_W-1:0] rd_insn_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [INSN_W-1:0] insn_o
);
  always_comb begin
    hit_o     = rd_valid_i && (rd_tag_i == fetch_pc_i[ADDR_W-1:IDX_W]);
    target_o  = hit_o ? rd_target_i : '0;
    insn_o    = hit_o ? rd_insn_i : '0;
    next_pc_o = (hit_o ? rd_target_i : fetch_pc_i) + ADDR_W'(1);
  end
endmodule

// File: rtl/jump_target_cache.sv
module jump_target_cache
  import jtc_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned INSN_W = DEF_INSN_W,
  parameter int unsigned IDX_W  = DEF_IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [INSN_W-1:0] insn_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic [INSN_W-1:0] upd_insn_i,
  input  logic              inv_valid_i,
  input  logic [ADDR_W-1:0] inv_pc_i
);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic              wr_en;
  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [ADDR_W-1:0] rd_target;
  logic [INSN_W-1:0] rd_insn;

  // sequential-flow jumps are not worth a slot
  assign wr_en = upd_valid_i && (upd_target_i != upd_pc_i + ADDR_W'(1));

  jtc_entry_array #(.ADDR_W(ADDR_W), .INSN_W(INSN_W), .IDX_W(IDX_W)) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_idx_i    (upd_pc_i[IDX_W-1:0]),
    .wr_tag_i    (upd_pc_i[ADDR_W-1:IDX_W]),
    .wr_target_i (upd_target_i),
    .wr_insn_i   (upd_insn_i),
    .clr_en_i    (inv_valid_i),
    .clr_idx_i   (inv_pc_i[IDX_W-1:0]),
    .clr_tag_i   (inv_pc_i[ADDR_W-1:IDX_W]),
    .rd_idx_i    (fetch_pc_i[IDX_W-1:0]),
    .rd_valid_o  (rd_valid),
    .rd_tag_o    (rd_tag),
    .rd_target_o (rd_target),
    .rd_insn_o   (rd_insn)
  );

  jtc_lookup #(.ADDR_W(ADDR_W), .INSN_W(INSN_W), .IDX_W(IDX_W)) u_lookup (
    .fetch_pc_i  (fetch_pc_i),
    .rd_valid_i  (rd_valid),
    .rd_tag_i    (rd_tag),
    .rd_target_i (rd_target),
    .rd_insn_i   (rd_insn),
    .hit_o       (hit_o),
    .next_pc_o   (next_pc_o),
    .target_o    (target_o),
    .insn_o      (insn_o)
  );
endmodule

// File: rtl/jtc_checker.sv
module jtc_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned INSN_W = 32,
  parameter int unsigned IDX_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] fetch_pc_i,
  input logic              hit_o,
  input logic [ADDR_W-1:0] next_pc_o,
  input logic [ADDR_W-1:0] target_o,
  input logic [INSN_W-1:0] insn_o,
  input logic              upd_valid_i,
  input logic [ADDR_W-1:0] upd_pc_i,
  input logic [ADDR_W-1:0] upd_target_i,
  input logic [INSN_W-1:0] upd_insn_i,
  input logic              inv_valid_i,
  input logic [ADDR_W-1:0] inv_pc_i
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  p_miss_seq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (next_pc_o == fetch_pc_i + ONE && insn_o == '0 && target_o == '0));

  p_hit_redirect_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> next_pc_o == target_o + ONE);

  p_install_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_target_i != upd_pc_i + ONE &&
     !(inv_valid_i && inv_pc_i[IDX_W-1:0] == upd_pc_i[IDX_W-1:0]))
    |=> (fetch_pc_i != $past(upd_pc_i)) ||
        (hit_o && target_o == $past(upd_target_i) && insn_o == $past(upd_insn_i)));

  p_no_seq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> target_o != fetch_pc_i + ONE);

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_i |=> (fetch_pc_i != $past(inv_pc_i)) || !hit_o);
endmodule

bind jump_target_cache jtc_checker #(.ADDR_W(ADDR_W), .INSN_W(INSN_W), .IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fetch_pc_i   (fetch_pc_i),
  .hit_o        (hit_o),
  .next_pc_o    (next_pc_o),
  .target_o     (target_o),
  .insn_o       (insn_o),
  .upd_valid_i  (upd_valid_i),
  .upd_pc_i     (upd_pc_i),
  .upd_target_i (upd_target_i),
  .upd_insn_i   (upd_insn_i),
  .inv_valid_i  (inv_valid_i),
  .inv_pc_i     (inv_pc_i)
);

// File: tb/tb_jump_target_cache.sv
module tb_jump_target_cache;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int IW = 32;

  typedef struct packed {
    logic          upd;
    logic          inv;
    logic [AW-1:0] pc;
    logic [AW-1:0] tgt;
    logic [IW-1:0] insn;
    logic [AW-1:0] fpc;
    logic          ehit;
    logic [AW-1:0] enext;
    logic [IW-1:0] einsn;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 16'h0000, 16'h0000, 32'h0,        16'h0010, 1'b0, 16'h0011, 32'h0,        8'd2},  // R2 empty miss
    '{1'b1, 1'b0, 16'h0010, 16'h0200, 32'hA1A1_0001, 16'h0010, 1'b0, 16'h0011, 32'h0,        8'd9},  // R9 install, old view
    '{1'b0, 1'b0, 16'h0000, 16'h0000, 32'h0,        16'h0010, 1'b1, 16'h0201, 32'hA1A1_0001, 8'd3},  // R3 hit
    '{1'b0, 1'b0, 16'h0000, 16'h0000, 32'h0,        16'h0020, 1'b0, 16'h0021, 32'h0,        8'd4},  // R4 alias miss
    '{1'b1, 1'b0, 16'h0010, 16'h0300, 32'hB2B2_0002, 16'h0010, 1'b1, 16'h0201, 32'hA1A1_0001, 8'd9},  // R9 correct, old view
    '{1'b0, 1'b0, 16'h0000, 16'h0000, 32'h0,        16'h0010, 1'b1, 16'h0301, 32'hB2B2_0002, 8'd5},  // R5 corrected
    '{1'b1, 1'b0, 16'h0010, 16'h0011, 32'hC3C3_0003, 16'h0555, 1'b0, 16'h0556, 32'h0,        8'd2},  // R2 other slot miss
    '{1'b0, 1'b0, 16'h0000, 16'h0000, 32'h0,        16'h0010, 1'b1, 16'h0301, 32'hB2B2_0002, 8'd7},  // R7 sequential dropped
    '{1'b1, 1'b0, 16'h0020, 16'h0400, 32'hD4D4_0004, 16'h0020, 1'b0, 16'h0021, 32'h0,        8'd9},  // R9 evicting write
    '{1'b0, 1'b0, 16'h0000, 16'h0000, 32'h0,        16'h0010, 1'b0, 16'h0011, 32'h0,        8'd6},  // R6 old jump gone
    '{1'b0, 1'b0, 16'h0000, 16'h0000, 32'h0,        16'h0020, 1'b1, 16'h0401, 32'hD4D4_0004, 8'd6},  // R6 new jump
    '{1'b0, 1'b1, 16'h0030, 16'h0000, 32'h0,        16'h0020, 1'b1, 16'h0401, 32'hD4D4_0004, 8'd8},  // R8 clear, wrong tag
    '{1'b0, 1'b0, 16'h0000, 16'h0000, 32'h0,        16'h0020, 1'b1, 16'h0401, 32'hD4D4_0004, 8'd8},  // R8 entry kept
    '{1'b0, 1'b1, 16'h0020, 16'h0000, 32'h0,        16'h0020, 1'b1, 16'h0401, 32'hD4D4_0004, 8'd9},  // R9 clear, old view
    '{1'b0, 1'b0, 16'h0000, 16'h0000, 32'h0,        16'h0020, 1'b0, 16'h0021, 32'h0,        8'd8},  // R8 cleared
    '{1'b1, 1'b1, 16'h0037, 16'h0100, 32'hE5E5_0005, 16'h0037, 1'b0, 16'h0038, 32'h0,        8'd10}, // R10 both
    '{1'b0, 1'b0, 16'h0000, 16'h0000, 32'h0,        16'h0037, 1'b0, 16'h0038, 32'h0,        8'd10}  // R10 clear wins
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] fetch_pc_i = '0;
  logic          hit_o;
  logic [AW-1:0] next_pc_o, target_o;
  logic [IW-1:0] insn_o;
  logic          upd_valid_i = 1'b0;
  logic [AW-1:0] upd_pc_i = '0, upd_target_i = '0;
  logic [IW-1:0] upd_insn_i = '0;
  logic          inv_valid_i = 1'b0;
  logic [AW-1:0] inv_pc_i = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  jump_target_cache dut (
    .clk_i, .rst_ni, .fetch_pc_i, .hit_o, .next_pc_o, .target_o, .insn_o,
    .upd_valid_i, .upd_pc_i, .upd_target_i, .upd_insn_i, .inv_valid_i, .inv_pc_i
  );

  task automatic check_out(input int req, input logic ehit, input logic [AW-1:0] enext,
                           input logic [IW-1:0] einsn);
    checks++;
    if (hit_o !== ehit || next_pc_o !== enext || insn_o !== einsn) begin
      errors++;
      $display("FAIL R%0d fetch=%h: hit/next/insn got %b/%h/%h expected %b/%h/%h",
               req, fetch_pc_i, hit_o, next_pc_o, insn_o, ehit, enext, einsn);
    end
  endtask

  task automatic apply(input logic u, input logic v, input logic [AW-1:0] pc,
                       input logic [AW-1:0] tgt, input logic [IW-1:0] insn,
                       input logic [AW-1:0] fpc);
    @(negedge clk_i);
    upd_valid_i = u; upd_pc_i = pc; upd_target_i = tgt; upd_insn_i = insn;
    inv_valid_i = v; inv_pc_i = pc;
    fetch_pc_i = fpc;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 during reset
    fetch_pc_i = 16'h0010;
    #1;
    check_out(1, 1'b0, 16'h0011, 32'h0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check_out(1, 1'b0, 16'h0011, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i].upd, TBL[i].inv, TBL[i].pc, TBL[i].tgt, TBL[i].insn, TBL[i].fpc);
      check_out(int'(TBL[i].req), TBL[i].ehit, TBL[i].enext, TBL[i].einsn);
    end

    // R3 redirect wraps past the top of the address space
    apply(1'b1, 1'b0, 16'hFFF5, 16'hFFFF, 32'h1234_5678, 16'h0000);
    apply(1'b0, 1'b0, 16'h0000, 16'h0000, 32'h0, 16'hFFF5);
    check_out(3, 1'b1, 16'h0000, 32'h1234_5678);
    checks++;
    if (target_o !== 16'hFFFF) begin
      errors++;
      $display("FAIL R3 target_o got %h expected ffff", target_o);
    end

    // R1 asynchronous reset wipes live entries
    apply(1'b1, 1'b0, 16'h0042, 16'h0900, 32'h0BAD_CAFE, 16'h0042);
    apply(1'b0, 1'b0, 16'h0000, 16'h0000, 32'h0, 16'h0042);
    check_out(3, 1'b1, 16'h0901, 32'h0BAD_CAFE);
    rst_ni = 1'b0;
    #1;
    check_out(1, 1'b0, 16'h0043, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    fetch_pc_i = 16'hFFF5;
    #1;
    check_out(1, 1'b0, 16'hFFF6, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule